// File: doc/BRIEF.md
# Double-Width Frame Segmenter and Reassembler

This block lets one narrow frame link carry a bus twice its width. On the sending side it accepts a wide word of 2×SEG_W bits and emits it as two SEG_W-bit segments on consecutive cycles. Each segment carries a marker flag that says which half it is. On the receiving side it watches the incoming data segments, pairs a first-half segment with the second-half segment that follows it, and presents the rebuilt wide word with a one-cycle valid pulse. The marker flag alone keeps the two ends aligned, so the link needs no extra sync words. A sequence that breaks the pairing raises a one-cycle error pulse, and the receiver then waits for the next first-half segment.

The whole block runs on the segment-rate clock. The wide-word rate is set by a ready/valid handshake: in double mode the sender drops ready for one cycle after each accepted word, so it takes wide words at half the segment rate. When the double-mode select `dbl_en` is low, both sides pass one narrow word per cycle unchanged, and the flag is a free user bit. SEG_W is 16 (32-bit bus) or 20 (40-bit bus). Line coding and serialization belong to neighbouring blocks.

Sender states: TX_IDLE (ready; an accepted double-mode word moves to TX_HIGH, an accepted single-mode word stays) and TX_HIGH (not ready; sends the upper half and returns to TX_IDLE). Receiver states: RX_HUNT (waiting for a first-half segment; one moves to RX_HOLD) and RX_HOLD (low half stored). From RX_HOLD, a second-half segment returns to RX_HUNT with a word. A repeated first-half segment stays in RX_HOLD with an error. A non-data segment returns to RX_HUNT with an error. A low `dbl_en` forces RX_HUNT from either state without an error.

Top module: `dfs_link`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `tx_seg_valid`, `rx_word_valid` and `rx_err` are 0 and `tx_word_ready` is 1.
- R2: With `dbl_en` low, a word accepted on cycle N appears on cycle N+1 as one segment. That segment holds the word's low SEG_W bits, its flag equals `tx_word_flag`, and `tx_word_ready` stays 1.
- R3: With `dbl_en` high, a word accepted on cycle N produces two segments. On cycle N+1 the segment holds bits [SEG_W-1:0] with flag 1 (first half). On cycle N+2 it holds bits [2·SEG_W-1:SEG_W] with flag 0 (second half).
- R4: With `dbl_en` high, `tx_word_ready` is 0 on the cycle after a word is accepted. A `tx_word_valid` on that cycle is not taken, and the word is accepted once ready returns.
- R5: In double mode, a data segment (`rx_seg_is_data`=1) with flag 1 followed by a data segment with flag 0 gives `rx_word_valid`=1 for one cycle, one cycle after the second. The word is {second, first}, and non-data-free idle cycles between the two are allowed.
- R6: In double mode, a flag-1 data segment that arrives while a first half is held pulses `rx_err`. The old half is discarded and the new segment becomes the held first half.
- R7: In double mode, a flag-0 data segment that arrives while no first half is held pulses `rx_err` and produces no word.
- R8: In double mode, a non-data segment that arrives while a first half is held pulses `rx_err` and drops the half. A non-data segment that arrives while nothing is held is ignored, with no error.
- R9: With `dbl_en` low, each received data segment gives a word {zeros, segment} with `rx_word_flag` equal to the segment flag. Non-data segments are ignored, and `rx_err` stays 0.
- R10: `rx_word_valid` and `rx_err` are never 1 on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Segment-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_en | input | 1 | 1 = split/merge wide words, 0 = pass narrow words |
| tx_word_valid | input | 1 | Wide word offered |
| tx_word_data | input | 2*SEG_W | Wide word to send |
| tx_word_flag | input | 1 | User flag bit for single mode |
| tx_word_ready | output | 1 | Sender can take a word this cycle |
| tx_seg_valid | output | 1 | Outgoing segment valid |
| tx_seg_data | output | SEG_W | Outgoing segment |
| tx_seg_flag | output | 1 | Outgoing flag: 1 first half, 0 second half (double mode) |
| rx_seg_valid | input | 1 | Incoming segment valid |
| rx_seg_is_data | input | 1 | 1 = data segment, 0 = control or fill |
| rx_seg_flag | input | 1 | Incoming flag bit |
| rx_seg_data | input | SEG_W | Incoming segment |
| rx_word_valid | output | 1 | One-cycle pulse: rebuilt word present |
| rx_word_data | output | 2*SEG_W | Rebuilt wide word |
| rx_word_flag | output | 1 | Segment flag in single mode, 0 in double mode |
| rx_err | output | 1 | One-cycle pulse: pairing broken |

## Verification
A wrong receiver state shows up on the very next segment as a misplaced pulse. A stale RX_HOLD turns a proper first half into a spurious `rx_err`, and a lost hold turns a proper second half into an error instead of a word. For this reason the bench pushes the orphan, repeat and abort cases back to back with normal pairs. On the sending side, a wrong state shows within one cycle: either as ready staying high after a double-mode accept, or as the halves coming out swapped or with the wrong flag. The reference model compares every output on every cycle, so a divergence is reported on the cycle it first occurs.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_HIGH = 1'b1
    } tx_st_t;

    typedef enum logic {
        RX_HUNT = 1'b0,
        RX_HOLD = 1'b1
    } rx_st_t;
endpackage

// File: rtl/dfs_tx_split.sv
module dfs_tx_split
    import dfs_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dbl_en,
    input  logic               in_valid,
    input  logic [2*SEG_W-1:0] in_data,
    input  logic               in_flag,
    output logic               in_ready,
    output logic               seg_valid,
    output logic [SEG_W-1:0]   seg_data,
    output logic               seg_flag
);
    localparam int WIDE_W = 2 * SEG_W;

    tx_st_t           state_q, state_d;
    logic [SEG_W-1:0] high_q;
    logic             accept;

    assign in_ready = (state_q == TX_IDLE);
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: state_d = (accept && dbl_en) ? TX_HIGH : TX_IDLE;
            TX_HIGH: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_valid <= 1'b0;
            seg_data  <= '0;
            seg_flag  <= 1'b0;
            high_q    <= '0;
        end else begin
            seg_valid <= 1'b0;
            unique case (state_q)
                TX_IDLE: begin
                    if (accept) begin
                        seg_valid <= 1'b1;
                        seg_data  <= in_data[SEG_W-1:0];
                        seg_flag  <= dbl_en ? 1'b1 : in_flag;
                        high_q    <= in_data[WIDE_W-1:SEG_W];
                    end
                end
                TX_HIGH: begin
                    seg_valid <= 1'b1;
                    seg_data  <= high_q;
                    seg_flag  <= 1'b0;
                end
            endcase
        end
    end

    // R4
    tx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && dbl_en) |=> !in_ready);

    // R3
    tx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && dbl_en) |=> (seg_valid && seg_flag) ##1 (seg_valid && !seg_flag));

    // R2
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !dbl_en) |=> (seg_valid && seg_data == $past(in_data[SEG_W-1:0])));
endmodule

// File: rtl/dfs_rx_merge.sv
module dfs_rx_merge
    import dfs_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dbl_en,
    input  logic               seg_valid,
    input  logic               seg_is_data,
    input  logic               seg_flag,
    input  logic [SEG_W-1:0]   seg_data,
    output logic               word_valid,
    output logic [2*SEG_W-1:0] word_data,
    output logic               word_flag,
    output logic               err
);
    localparam int WIDE_W = 2 * SEG_W;

    rx_st_t           state_q, state_d;
    logic [SEG_W-1:0] low_q;
    logic             data_seg;
    logic             fire_single, fire_pair, fire_err, load_low;

    assign data_seg = seg_valid && seg_is_data;

    always_comb begin
        state_d     = state_q;
        fire_single = 1'b0;
        fire_pair   = 1'b0;
        fire_err    = 1'b0;
        load_low    = 1'b0;
        if (!dbl_en) begin
            state_d     = RX_HUNT;
            fire_single = data_seg;
        end else begin
            unique case (state_q)
                RX_HUNT: begin
                    if (data_seg && seg_flag) begin
                        load_low = 1'b1;
                        state_d  = RX_HOLD;
                    end else if (data_seg) begin
                        fire_err = 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (seg_valid && !seg_is_data) begin
                        fire_err = 1'b1;
                        state_d  = RX_HUNT;
                    end else if (data_seg && seg_flag) begin
                        fire_err = 1'b1;
                        load_low = 1'b1;
                    end else if (data_seg) begin
                        fire_pair = 1'b1;
                        state_d   = RX_HUNT;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
            word_flag  <= 1'b0;
            err        <= 1'b0;
            low_q      <= '0;
        end else begin
            word_valid <= fire_single || fire_pair;
            err        <= fire_err;
            if (load_low) low_q <= seg_data;
            if (fire_single) begin
                word_data <= {{SEG_W{1'b0}}, seg_data};
                word_flag <= seg_flag;
            end else if (fire_pair) begin
                word_data <= {seg_data, low_q};
                word_flag <= 1'b0;
            end
        end
    end

    // R10
    err_word_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && err));

    // R5
    word_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(seg_valid && seg_is_data));

    // R7
    orphan_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_en && state_q == RX_HUNT && seg_valid && seg_is_data && !seg_flag) |=> (err && !word_valid));

    // R8
    hold_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_en && state_q == RX_HOLD && seg_valid && !seg_is_data) |=> err);

    // R6
    repeat_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_en && state_q == RX_HOLD && seg_valid && seg_is_data && seg_flag) |=> (err && state_q == RX_HOLD));

    // R9
    single_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dbl_en |=> !err);
endmodule

// File: rtl/dfs_link.sv
module dfs_link #(
    parameter int SEG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dbl_en,
    input  logic               tx_word_valid,
    input  logic [2*SEG_W-1:0] tx_word_data,
    input  logic               tx_word_flag,
    output logic               tx_word_ready,
    output logic               tx_seg_valid,
    output logic [SEG_W-1:0]   tx_seg_data,
    output logic               tx_seg_flag,
    input  logic               rx_seg_valid,
    input  logic               rx_seg_is_data,
    input  logic               rx_seg_flag,
    input  logic [SEG_W-1:0]   rx_seg_data,
    output logic               rx_word_valid,
    output logic [2*SEG_W-1:0] rx_word_data,
    output logic               rx_word_flag,
    output logic               rx_err
);
    dfs_tx_split #(.SEG_W(SEG_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbl_en    (dbl_en),
        .in_valid  (tx_word_valid),
        .in_data   (tx_word_data),
        .in_flag   (tx_word_flag),
        .in_ready  (tx_word_ready),
        .seg_valid (tx_seg_valid),
        .seg_data  (tx_seg_data),
        .seg_flag  (tx_seg_flag)
    );

    dfs_rx_merge #(.SEG_W(SEG_W)) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbl_en      (dbl_en),
        .seg_valid   (rx_seg_valid),
        .seg_is_data (rx_seg_is_data),
        .seg_flag    (rx_seg_flag),
        .seg_data    (rx_seg_data),
        .word_valid  (rx_word_valid),
        .word_data   (rx_word_data),
        .word_flag   (rx_word_flag),
        .err         (rx_err)
    );
endmodule

// File: tb/dfs_link_tb_top.sv
module dfs_link_tb_top;
    localparam int SW = 16;
    localparam int WW = 2 * SW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dbl_en;
    logic          tx_word_valid;
    logic [WW-1:0] tx_word_data;
    logic          tx_word_flag;
    logic          tx_word_ready;
    logic          tx_seg_valid;
    logic [SW-1:0] tx_seg_data;
    logic          tx_seg_flag;
    logic          rx_seg_valid;
    logic          rx_seg_is_data;
    logic          rx_seg_flag;
    logic [SW-1:0] rx_seg_data;
    logic          rx_word_valid;
    logic [WW-1:0] rx_word_data;
    logic          rx_word_flag;
    logic          rx_err;

    int total = 0;
    int bad   = 0;

    bit          m_pend = 0;
    bit [SW-1:0] m_hi   = '0;
    bit          m_hold = 0;
    bit [SW-1:0] m_lo   = '0;

    always #4 clk = ~clk;

    dfs_link #(.SEG_W(SW)) dut_i (.*);

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag);
        bit          e_sv, e_sf, e_wv, e_wf, e_err;
        bit [SW-1:0] e_sd;
        bit [WW-1:0] e_wd;
        e_sv = 0; e_sf = 0; e_sd = '0; e_wv = 0; e_wf = 0; e_err = 0; e_wd = '0;
        chk(tag, "ready", tx_word_ready, !m_pend);
        if (m_pend) begin
            e_sv = 1; e_sd = m_hi; e_sf = 0; m_pend = 0;
        end else if (tx_word_valid) begin
            e_sv = 1; e_sd = tx_word_data[SW-1:0];
            if (dbl_en) begin
                e_sf = 1; m_pend = 1; m_hi = tx_word_data[WW-1:SW];
            end else begin
                e_sf = tx_word_flag;
            end
        end
        if (!dbl_en) begin
            m_hold = 0;
            if (rx_seg_valid && rx_seg_is_data) begin
                e_wv = 1; e_wd = {{SW{1'b0}}, rx_seg_data}; e_wf = rx_seg_flag;
            end
        end else if (rx_seg_valid) begin
            if (m_hold) begin
                if (!rx_seg_is_data) begin
                    e_err = 1; m_hold = 0;
                end else if (rx_seg_flag) begin
                    e_err = 1; m_lo = rx_seg_data;
                end else begin
                    e_wv = 1; e_wd = {rx_seg_data, m_lo}; e_wf = 0; m_hold = 0;
                end
            end else if (rx_seg_is_data) begin
                if (rx_seg_flag) begin
                    m_lo = rx_seg_data; m_hold = 1;
                end else begin
                    e_err = 1;
                end
            end
        end
        @(posedge clk);
        #1;
        chk(tag, "seg_valid", tx_seg_valid, e_sv);
        if (e_sv) begin
            chk(tag, "seg_data", tx_seg_data, e_sd);
            chk(tag, "seg_flag", tx_seg_flag, e_sf);
        end
        chk(tag, "word_valid", rx_word_valid, e_wv);
        chk(tag, "err", rx_err, e_err);
        if (e_wv) begin
            chk(tag, "word_data", rx_word_data, e_wd);
            chk(tag, "word_flag", rx_word_flag, e_wf);
        end
    endtask

    task automatic idle_in();
        tx_word_valid = 0;
        rx_seg_valid  = 0;
        rx_seg_is_data = 0;
        rx_seg_flag   = 0;
    endtask

    task automatic rx_put(bit d, bit f, bit [SW-1:0] v, string tag);
        rx_seg_valid = 1; rx_seg_is_data = d; rx_seg_flag = f; rx_seg_data = v;
        cyc(tag);
        idle_in();
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; dbl_en = 0; tx_word_data = '0; tx_word_flag = 0; rx_seg_data = '0;
        idle_in();
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "reset seg_valid", tx_seg_valid, 0);
        chk("R1", "reset word_valid", rx_word_valid, 0);
        chk("R1", "reset err", rx_err, 0);
        chk("R1", "reset ready", tx_word_ready, 1);
        rst_n = 1;
        cyc("R1");

        // R2 single-mode send, several patterns, back to back
        for (int i = 0; i < 4; i++) begin
            tx_word_valid = 1;
            tx_word_data  = 32'hA5A5_0000 + 32'(i * 16'h1111);
            tx_word_flag  = i[0];
            cyc("R2");
        end
        idle_in();
        cyc("R2");

        // R3 R4 double-mode send with valid held high
        dbl_en = 1;
        cyc("R3");
        for (int i = 0; i < 6; i++) begin
            tx_word_valid = 1;
            tx_word_data  = {16'(16'hC000 + i), 16'(16'h0100 + i)};
            cyc("R4");
        end
        idle_in();
        cyc("R3");
        cyc("R3");

        // R5 normal pairs, with and without a gap
        rx_put(1, 1, 16'h1234, "R5");
        rx_put(1, 0, 16'hABCD, "R5");
        rx_put(1, 1, 16'h0F0F, "R5");
        cyc("R5");
        rx_put(1, 0, 16'hF0F0, "R5");
        // R8 fill while hunting is ignored
        rx_put(0, 0, 16'h7777, "R8");
        rx_put(0, 1, 16'h7778, "R8");
        // R6 repeated first half
        rx_put(1, 1, 16'h1111, "R6");
        rx_put(1, 1, 16'h2222, "R6");
        rx_put(1, 0, 16'h3333, "R6");
        // R7 orphan second half, twice in a row
        rx_put(1, 0, 16'h4444, "R7");
        rx_put(1, 0, 16'h4445, "R7");
        rx_put(1, 1, 16'h5555, "R7");
        rx_put(1, 0, 16'h6666, "R7");
        // R8 control frame between halves
        rx_put(1, 1, 16'h8888, "R8");
        rx_put(0, 1, 16'h9999, "R8");
        rx_put(1, 0, 16'hAAAA, "R8");
        rx_put(1, 1, 16'hBBBB, "R8");
        rx_put(1, 0, 16'hCCCC, "R8");

        // both sides at once: send and receive in the same cycles (R10)
        for (int i = 0; i < 8; i++) begin
            tx_word_valid = (i % 3) != 2;
            tx_word_data  = {16'(i * 7), 16'(i * 13)};
            rx_seg_valid  = 1;
            rx_seg_is_data = (i != 5);
            rx_seg_flag   = (i % 2) == 0;
            rx_seg_data   = 16'(16'hD000 + i);
            cyc("R10");
        end
        idle_in();
        cyc("R10");
        cyc("R10");

        // R9 single-mode receive
        dbl_en = 0;
        rx_put(1, 1, 16'hBEEF, "R9");
        rx_put(1, 0, 16'hCAFE, "R9");
        rx_put(0, 1, 16'hDEAD, "R9");
        rx_put(1, 1, 16'h0001, "R9");
        cyc("R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule